// File: doc/BRIEF.md
# Synchronous Serial Shift Port

This block is an 8-bit full-duplex serial shifter that sits on a small CPU register bus. Software writes a byte into the data register. The block sends that byte out on the serial data output, most significant bit first, and at the same time collects a byte from the serial data input. When the byte is done, the received value replaces the contents of the data register. A completion flag and a collision flag are visible in a read-only status register.

The port works in one of two roles. In master role it generates the serial clock itself, at one quarter of the system clock rate, and drives the clock pin. In slave role it leaves the clock pin as an input and follows an external clock, which it brings into the system clock domain through a synchronizer. While the port is disabled its output enables are low, so the pins belong to general-purpose I/O. Clearing the enable bit in the middle of a byte aborts the transfer on the spot.

The bus has three registers. Address 0 is control: bit 0 is the port enable and bit 1 is the master select. Address 1 is status. Address 2 is data. Bus strobes last one clock, write data is taken at the clock edge, and read data is combinational.

Top module: `sio_shift_port`

## Requirements
- R1: After reset the control register reads 0x00 and the status register reads 0x00. Both output enables (`sck_oe`, `sdo_oe`) are low and `sck_out` is high.
- R2: The status register holds the completion flag in bit 7 and the collision flag in bit 6. Bits 5 to 0 always read 0, and a bus write to the status address changes nothing.
- R3: In master role, a data write while the port is enabled and idle starts a transfer. The byte leaves MSB first, with the output changing on the falling serial clock edge. The input is sampled on the rising edge. After the transfer a data read returns the received byte.
- R4: The master serial clock runs at the system clock divided by 4 and rests high between transfers. The completion flag first reads as set 31 clocks after the clock edge that takes the starting data write.
- R5: The completion flag is set on the eighth rising serial clock edge of a transfer. A flag that is already set does not stop the next transfer from running.
- R6: Both flags clear only on a data read or a data write that follows a status read made while a flag was set. A data access with no such status read before it leaves the completion flag set.
- R7: Any data access (read or write) while a transfer is in progress sets the collision flag. A data write made during a transfer is dropped, and the byte being shifted is unchanged.
- R8: Writing 0 to the enable bit during a transfer aborts it. The bit counter goes back to zero, the clock returns high, both output enables drop, and no completion flag is raised. A later transfer runs the full 8 bits.
- R9: The master select bit can be written while the port is disabled and reads back as written. `sdo_oe` equals the enable bit, and `sck_oe` is high only when the port is both enabled and master.
- R10: In slave role the port shifts on edges of the external `sck_in` (output on falling edges, input on rising edges). It sets the completion flag after the eighth rising edge, and a data read then returns the byte it received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| cpu_wr | input | 1 | One-cycle write strobe |
| cpu_rd | input | 1 | One-cycle read strobe; read side effects apply at the clock edge |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Combinational read data for `cpu_addr` |
| sck_in | input | 1 | Serial clock input for slave role |
| sck_out | output | 1 | Serial clock generated in master role, high at rest |
| sck_oe | output | 1 | Drive enable for the clock pin |
| sdi_in | input | 1 | Serial data input |
| sdo_out | output | 1 | Serial data output |
| sdo_oe | output | 1 | Drive enable for the data output pin |

## Verification
The bound assertions watch the following on every cycle:
- the zero padding of the status register;
- the pin release and counter clear that follow a disabling control write;
- the collision flag being raised and the shift register staying put when a data access lands mid-transfer;
- the completion flag holding until its clear sequence;
- the flag rising only on the eighth rising edge;
- the clock resting high when the port is idle.

Only the bench's scenarios can show that whole bytes travel MSB first in both directions, the exact 31-clock latency, that an aborted byte leaves no trace on the next one, and that slave role tracks an external clock. The bench shows this with a sweep over all 256 master byte values against a modelled peer and a set of slave byte values.

// File: rtl/sio_pkg.sv
package sio_pkg;

   // Register addresses on the CPU side
   typedef enum logic [1:0] {
      SIO_CTRL = 2'd0,
      SIO_STAT = 2'd1,
      SIO_DATA = 2'd2,
      SIO_NONE = 2'd3
   } sio_reg_e;

   // Control register field positions
   localparam int CTRL_EN_BIT = 0;
   localparam int CTRL_MS_BIT = 1;

   // Decoded one-cycle bus accesses
   typedef struct packed {
      logic wr_ctrl;
      logic rd_stat;
      logic rd_data;
      logic wr_data;
   } sio_acc_t;

endpackage

// File: rtl/sio_mclk.sv
// Master serial clock generator: free divider while running, pulses for
// the falling and rising serial edges, clock pin register resting high.
module sio_mclk #(
   parameter int CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic stop,
   output logic fall,
   output logic rise,
   output logic run,
   output logic sck
);
   localparam int DW = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
   localparam logic [DW-1:0] HALF_V = DW'(CLK_DIV / 2);
   localparam logic [DW-1:0] WRAP_V = DW'(CLK_DIV - 1);

   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("sio_mclk: CLK_DIV must be even and at least 2");
      end
   endgenerate

   logic [DW-1:0] div_q;
   logic          run_q;
   logic          sck_q;

   assign fall = run_q && (div_q == '0);
   assign rise = run_q && (div_q == HALF_V);
   assign run  = run_q;
   assign sck  = sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         run_q <= 1'b0;
         sck_q <= 1'b1;
      end else if (stop) begin
         div_q <= '0;
         run_q <= 1'b0;
         sck_q <= 1'b1;
      end else if (start) begin
         div_q <= '0;
         run_q <= 1'b1;
         sck_q <= 1'b1;
      end else if (run_q) begin
         div_q <= (div_q == WRAP_V) ? '0 : div_q + 1'b1;
         if (fall) sck_q <= 1'b0;
         if (rise) sck_q <= 1'b1;
      end
   end

endmodule

// File: rtl/sio_ssync.sv
// Slave clock front end: synchronizer chain and edge detector.
module sio_ssync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck_in,
   output logic fall,
   output logic rise
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sio_ssync: STAGES must be at least 2");
      end
   endgenerate

   // chain[STAGES-1] is the synchronized level, chain[STAGES] its last value
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-1:0], sck_in};
   end

   assign fall =  chain[STAGES] && !chain[STAGES-1];
   assign rise = !chain[STAGES] &&  chain[STAGES-1];

endmodule

// File: rtl/sio_shifter.sv
// Shift register, output bit and bit counter shared by both roles.
module sio_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         fall,
   input  logic         rise,
   input  logic         clr,
   input  logic         sdi,
   output logic [W-1:0] shreg,
   output logic         sdo,
   output logic [$clog2(W)-1:0] bit_cnt,
   output logic         last
);
   localparam int CW = $clog2(W);
   localparam logic [CW-1:0] TOP_V = CW'(W - 1);

   logic [W-1:0]  sh_q;
   logic          sdo_q;
   logic [CW-1:0] cnt_q;

   assign last    = rise && (cnt_q == TOP_V) && !clr;
   assign shreg   = sh_q;
   assign sdo     = sdo_q;
   assign bit_cnt = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (rise) begin
         cnt_q <= (cnt_q == TOP_V) ? '0 : cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (load) begin
         sh_q <= load_val;
      end else if (rise) begin
         sh_q <= {sh_q[W-2:0], sdi};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sdo_q <= 1'b0;
      else if (fall) sdo_q <= sh_q[W-1];
   end

endmodule

// File: rtl/sio_regs.sv
// Control bits, status flags and the two-step flag clear sequence.
module sio_regs
   import sio_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  sio_acc_t acc,
   input  logic     wr_en_bit,
   input  logic     wr_ms_bit,
   input  logic     busy,
   input  logic     last,
   output logic     en,
   output logic     ms,
   output logic     done,
   output logic     coll,
   output logic     armed
);
   logic data_acc;
   assign data_acc = acc.rd_data || acc.wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en <= 1'b0;
         ms <= 1'b0;
      end else if (acc.wr_ctrl) begin
         en <= wr_en_bit;
         ms <= wr_ms_bit;
      end
   end

   // Arming: a status read that sees a flag set; consumed by any data access
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         armed <= 1'b0;
      else if (data_acc)                  armed <= 1'b0;
      else if (acc.rd_stat && (done || coll)) armed <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    done <= 1'b0;
      else if (last)                 done <= 1'b1;
      else if (data_acc && armed)    done <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    coll <= 1'b0;
      else if (data_acc && busy)     coll <= 1'b1;
      else if (data_acc && armed)    coll <= 1'b0;
   end

endmodule

// File: rtl/sio_shift_port.sv
module sio_shift_port
   import sio_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CLK_DIV     = 4,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_SLAVE   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cpu_addr,
   input  logic              cpu_wr,
   input  logic              cpu_rd,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              sck_in,
   output logic              sck_out,
   output logic              sck_oe,
   input  logic              sdi_in,
   output logic              sdo_out,
   output logic              sdo_oe
);
   localparam int CW = $clog2(DATA_W);

   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("sio_shift_port: DATA_W must be at least 4");
      end
   endgenerate

   sio_acc_t      acc;
   logic          en_q, ms_q, st_done, st_coll, clr_armed;
   logic          busy, load, start, abort;
   logic          m_fall, m_rise, m_run, m_sck;
   logic          s_fall, s_rise;
   logic          sh_fall, sh_rise, sh_last;
   logic [CW-1:0] bit_cnt;
   logic [DATA_W-1:0] shreg;

   // Bus decode
   always_comb begin
      acc.wr_ctrl = cpu_wr && (cpu_addr == SIO_CTRL);
      acc.rd_stat = cpu_rd && (cpu_addr == SIO_STAT);
      acc.rd_data = cpu_rd && (cpu_addr == SIO_DATA);
      acc.wr_data = cpu_wr && (cpu_addr == SIO_DATA);
   end

   assign busy  = m_run || (bit_cnt != '0);
   assign load  = acc.wr_data && !busy;
   assign start = load && en_q && ms_q;
   assign abort = acc.wr_ctrl && !cpu_wdata[CTRL_EN_BIT];

   sio_regs u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc       (acc),
      .wr_en_bit (cpu_wdata[CTRL_EN_BIT]),
      .wr_ms_bit (cpu_wdata[CTRL_MS_BIT]),
      .busy      (busy),
      .last      (sh_last),
      .en        (en_q),
      .ms        (ms_q),
      .done      (st_done),
      .coll      (st_coll),
      .armed     (clr_armed)
   );

   sio_mclk #(.CLK_DIV(CLK_DIV)) u_mclk (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .stop  (abort || sh_last),
      .fall  (m_fall),
      .rise  (m_rise),
      .run   (m_run),
      .sck   (m_sck)
   );

   generate
      if (HAS_SLAVE) begin : g_slave
         sio_ssync #(.STAGES(SYNC_STAGES)) u_ssync (
            .clk    (clk),
            .rst_n  (rst_n),
            .sck_in (sck_in),
            .fall   (s_fall),
            .rise   (s_rise)
         );
      end else begin : g_no_slave
         assign s_fall = 1'b0;
         assign s_rise = 1'b0;
      end
   endgenerate

   // Edge source selected by role, gated by the enable
   assign sh_fall = en_q && (ms_q ? m_fall : s_fall);
   assign sh_rise = en_q && (ms_q ? m_rise : s_rise);

   sio_shifter #(.W(DATA_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (cpu_wdata),
      .fall     (sh_fall),
      .rise     (sh_rise),
      .clr      (abort),
      .sdi      (sdi_in),
      .shreg    (shreg),
      .sdo      (sdo_out),
      .bit_cnt  (bit_cnt),
      .last     (sh_last)
   );

   assign sck_out = m_sck;
   assign sck_oe  = en_q && ms_q;
   assign sdo_oe  = en_q;

   always_comb begin
      cpu_rdata = '0;
      case (cpu_addr)
         SIO_CTRL: begin
            cpu_rdata[CTRL_EN_BIT] = en_q;
            cpu_rdata[CTRL_MS_BIT] = ms_q;
         end
         SIO_STAT: begin
            cpu_rdata[DATA_W-1] = st_done;
            cpu_rdata[DATA_W-2] = st_coll;
         end
         SIO_DATA: cpu_rdata = shreg;
         default:  cpu_rdata = '0;
      endcase
   end

endmodule

// File: rtl/sio_shift_port_chk.sv
module sio_shift_port_chk #(
   parameter int W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       cpu_addr,
   input logic             cpu_wr,
   input logic             cpu_rd,
   input logic             wr_en_bit,
   input logic [W-3:0]     stat_pad,
   input logic             sck_out,
   input logic             sck_oe,
   input logic             sdo_oe,
   input logic             busy,
   input logic             done,
   input logic             coll,
   input logic             armed,
   input logic             rise,
   input logic [$clog2(W)-1:0] bit_cnt,
   input logic [W-1:0]     shreg
);
   localparam logic [$clog2(W)-1:0] TOP_V = ($clog2(W))'(W - 1);

   logic data_acc, ctrl_off;
   assign data_acc = (cpu_wr || cpu_rd) && (cpu_addr == 2'd2);
   assign ctrl_off = cpu_wr && (cpu_addr == 2'd0) && !wr_en_bit;

   AST_STAT_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_addr == 2'd1) |-> (stat_pad == '0)); // R2

   AST_SCK_REST_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sck_out); // R4

   AST_DONE_ON_EIGHTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(rise && (bit_cnt == TOP_V))); // R5

   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !(data_acc && armed)) |=> done); // R6

   AST_COLL_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && busy) |=> coll); // R7

   AST_BUSY_WR_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && (cpu_addr == 2'd2) && busy && !rise) |=> (shreg == $past(shreg))); // R7

   AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_off |=> (!sck_oe && !sdo_oe && sck_out)); // R8

   AST_ABORT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_off |=> (bit_cnt == '0)); // R8

   AST_OE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      sck_oe |-> sdo_oe); // R9

endmodule

bind sio_shift_port sio_shift_port_chk #(.W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cpu_addr  (cpu_addr),
   .cpu_wr    (cpu_wr),
   .cpu_rd    (cpu_rd),
   .wr_en_bit (cpu_wdata[0]),
   .stat_pad  (cpu_rdata[DATA_W-3:0]),
   .sck_out   (sck_out),
   .sck_oe    (sck_oe),
   .sdo_oe    (sdo_oe),
   .busy      (busy),
   .done      (st_done),
   .coll      (st_coll),
   .armed     (clr_armed),
   .rise      (sh_rise),
   .bit_cnt   (bit_cnt),
   .shreg     (shreg)
);

// File: tb/sim_sio_shift_port.sv
module sim_sio_shift_port;
   localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] cpu_addr = 2'd0;
   logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
   logic [7:0] cpu_wdata = 8'h00;
   logic [7:0] cpu_rdata;
   logic       sck_out, sck_oe, sdo_out, sdo_oe, sdi_in;
   logic       tb_sck = 1'b1, tb_sdi = 1'b0, slave_tb = 1'b0;
   logic       peer_sdi = 1'b0;
   logic [7:0] peer_tx = 8'h00, peer_rx = 8'h00;
   int         peer_idx = 0;
   int         vecs = 0, errs = 0;
   bit         finished = 1'b0;

   always #4 clk = ~clk;

   assign sdi_in = slave_tb ? tb_sdi : peer_sdi;

   sio_shift_port u0 (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
      .cpu_rd(cpu_rd), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
      .sck_in(tb_sck), .sck_out(sck_out), .sck_oe(sck_oe),
      .sdi_in(sdi_in), .sdo_out(sdo_out), .sdo_oe(sdo_oe));

   // Peer device for master role: drives on falling, samples on rising
   always @(negedge sck_out) if (!slave_tb && peer_idx < 8) peer_sdi <= peer_tx[7-peer_idx];
   always @(posedge sck_out) if (!slave_tb) begin
      peer_rx  <= {peer_rx[6:0], sdo_out};
      peer_idx <= peer_idx + 1;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vecs++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      cpu_addr = a; cpu_rd = 1'b1;
      #1 d = cpu_rdata;
      @(negedge clk);
      cpu_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Full master transfer with polling; checks latency, both bytes, clearing
   task automatic xfer_m(input logic [7:0] v, input logic [7:0] p);
      logic [7:0] s, d;
      int lat;
      peer_tx = p; peer_idx = 0;
      wr(A_DATA, v);
      lat = -1;
      for (int k = 0; k < 48; k++) begin
         rd(A_STAT, s);
         if (s[7]) begin lat = k; break; end
      end
      chk("R4 done latency", lat, 31);
      rd(A_DATA, d);
      chk("R3 received byte", {24'd0, d}, {24'd0, p});
      chk("R3 peer saw MSB-first byte", {24'd0, peer_rx}, {24'd0, v});
      rd(A_STAT, s);
      chk("R6 flags cleared", {24'd0, s}, 32'd0);
   endtask

   task automatic xfer_s(input logic [7:0] v, input logic [7:0] p);
      logic [7:0] s, d, got;
      got = 8'h00;
      wr(A_DATA, v);
      for (int b = 7; b >= 0; b--) begin
         tb_sck = 1'b0; tb_sdi = p[b];
         idle(8);
         got = {got[6:0], sdo_out};
         tb_sck = 1'b1;
         idle(8);
      end
      rd(A_STAT, s);
      chk("R10 slave done", {24'd0, s}, 32'h80);
      rd(A_DATA, d);
      chk("R10 slave received", {24'd0, d}, {24'd0, p});
      chk("R10 slave sent", {24'd0, got}, {24'd0, v});
   endtask

   initial begin
      logic [7:0] s, d;
      idle(3);
      rst_n = 1'b1;
      idle(2);
      // R1 reset state
      rd(A_CTRL, d);  chk("R1 ctrl", {24'd0, d}, 32'd0);
      rd(A_STAT, s);  chk("R1 status", {24'd0, s}, 32'd0);
      chk("R1 oe", {30'd0, sck_oe, sdo_oe}, 32'd0);
      chk("R1 sck rest", {31'd0, sck_out}, 32'd1);
      // R2 status read-only
      wr(A_STAT, 8'hFF);
      rd(A_STAT, s);  chk("R2 status write ignored", {24'd0, s}, 32'd0);
      // R9 master select while disabled, pin enables
      wr(A_CTRL, 8'h02);
      rd(A_CTRL, d);  chk("R9 ms readback", {24'd0, d}, 32'h02);
      chk("R9 oe disabled", {30'd0, sck_oe, sdo_oe}, 32'd0);
      wr(A_CTRL, 8'h01);
      chk("R9 oe slave", {30'd0, sck_oe, sdo_oe}, 32'd1);
      wr(A_CTRL, 8'h03);
      chk("R9 oe master", {30'd0, sck_oe, sdo_oe}, 32'd3);
      // R3/R4 sweep all byte values in master role
      for (int v = 0; v < 256; v++)
         xfer_m(8'(v), 8'((v * 7 + 8'h35) & 8'hFF));
      // R5 and R6: flag set without status read, then another transfer
      peer_tx = 8'hEE; peer_idx = 0;
      wr(A_DATA, 8'h11);
      idle(40);
      chk("R4 sck rests high", {31'd0, sck_out}, 32'd1);
      rd(A_DATA, d);  chk("R3 data after idle wait", {24'd0, d}, 32'hEE);
      rd(A_STAT, s);  chk("R6 data read alone keeps flag", {24'd0, s}, 32'h80);
      wr(A_CTRL, 8'h03);
      peer_tx = 8'h5A; peer_idx = 0;
      wr(A_DATA, 8'h22);
      rd(A_STAT, s);  chk("R6 status-then-write clears", {24'd0, s}, 32'h00);
      idle(40);
      chk("R5 next transfer ran", {24'd0, peer_rx}, 32'h22);
      rd(A_STAT, s);  chk("R5 done set again", {24'd0, s}, 32'h80);
      rd(A_DATA, d);  chk("R5 second received", {24'd0, d}, 32'h5A);
      // R5: a set flag that was never cleared does not block the next byte
      peer_tx = 8'hC3; peer_idx = 0;
      wr(A_DATA, 8'h77);
      idle(40);
      peer_tx = 8'h0F; peer_idx = 0;
      wr(A_DATA, 8'h88);
      idle(40);
      chk("R5 flag does not block", {24'd0, peer_rx}, 32'h88);
      rd(A_STAT, s);  rd(A_DATA, d);
      chk("R5 byte after unblocked run", {24'd0, d}, 32'h0F);
      // R7 collision
      peer_tx = 8'h3C; peer_idx = 0;
      wr(A_DATA, 8'h96);
      idle(6);
      wr(A_DATA, 8'h00);
      rd(A_STAT, s);  chk("R7 write sets collision", {24'd0, s}, 32'h40);
      rd(A_DATA, d);
      idle(40);
      rd(A_STAT, s);  chk("R7 read also collides, R2 pad", {24'd0, s}, 32'hC0);
      rd(A_DATA, d);  chk("R7 dropped write", {24'd0, d}, 32'h3C);
      chk("R7 original byte sent", {24'd0, peer_rx}, 32'h96);
      rd(A_STAT, s);  chk("R7 collision cleared", {24'd0, s}, 32'h00);
      // R8 abort
      peer_tx = 8'hFF; peer_idx = 0;
      wr(A_DATA, 8'hA5);
      idle(10);
      wr(A_CTRL, 8'h02);
      chk("R8 pins released", {29'd0, sck_oe, sdo_oe, sck_out}, 32'd1);
      idle(40);
      rd(A_STAT, s);  chk("R8 no done after abort", {24'd0, s}, 32'h00);
      wr(A_CTRL, 8'h03);
      xfer_m(8'h5C, 8'hB1);
      // R10 slave role
      wr(A_CTRL, 8'h01);
      slave_tb = 1'b1;
      chk("R10 clock pin input", {31'd0, sck_oe}, 32'd0);
      for (int v = 0; v < 16; v++)
         xfer_s(8'((v * 17 + 3) & 8'hFF), 8'((v * 29 + 8'h81) & 8'hFF));
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         vecs++; errs++;
         $display("FAIL watchdog: run did not complete actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
         $finish;
      end
   end

endmodule